// File: doc/BRIEF.md
# Banked BCD Calendar Clock Core

This core keeps the time of day and the calendar as a set of 4-bit BCD digit registers: seconds, minutes, hours, day of week, day, month and a four-digit year. Software reaches every digit through a plain nibble-wide register port. Register index `n` sits at byte address `4*n`. A control register at index 15 is visible in every bank. It carries a read-only busy flag, a stop bit and a 2-bit bank select. Bank 0 holds the time digits. The other banks are reserved at this level, so their digit slots read as zero.

A single-cycle `sec_tick` pulse arrives once per second. It starts a sequential update: one cycle adds one to the seconds pair, and each further cycle takes a carry into the next field (minutes, hours, day with day of week, month, year). Busy is high for exactly those cycles. Software polls busy and reads the digits only when it is low. To load a new time, software sets stop, writes the digits and then clears stop. A tick that arrives while stop is set is dropped.

Top module: `bcd_cal_clock`

## Requirements
- R1: A read returns the addressed 4-bit value in bits [3:0], and all higher read data bits are zero. A write stores only write-data bits [3:0]. The register index is taken from address bits [5:2], so address bits [1:0] do not change which register is selected.
- R2: In bank 0 the indices hold: 0 seconds units, 1 seconds tens, 2 minutes units, 3 minutes tens, 4 hours units, 5 hours tens, 6 day of week, 7 day units, 8 day tens, 9 month units, 10 month tens, 11 year units, 12 year tens, 13 year hundreds, 14 year thousands.
- R3: Index 15 is the control register in every bank. Bit 0 is busy and read-only (a written value has no effect). Bit 1 is stop. Bits [3:2] are the bank select.
- R4: After reset the time reads 2000-01-01 00:00:00 with day of week 0, and the control register reads 0.
- R5: A tick while stop is clear and busy is low makes busy read 1 in the next cycle and adds one second to the time.
- R6: Seconds and minutes wrap 59 to 00 with a carry to the next field. Hours wrap 23 to 00 with a carry into the day.
- R7: The day wraps to 01 after the last day of the month: 31 for months 1, 3, 5, 7, 8, 10 and 12, 30 for months 4, 6, 9 and 11, and 28 for February, or 29 in a leap year. A year is a leap year if it is divisible by 4, except for century years not divisible by 400.
- R8: Months count 1 to 12, and 12 wraps to 1 with a carry into the year. The year counts through four decimal digits, and 9999 wraps to 0000.
- R9: Each carry into the day advances the day of week by one, counting 0 to 6, with 6 wrapping to 0.
- R10: A tick while stop is set is discarded. Busy stays low, the time is unchanged, and no update takes place after stop is cleared. Counting resumes with the next tick.
- R11: With a nonzero bank selected, indices 0 to 14 read as zero, and writes to them leave the time digits unchanged.
- R12: Busy stays high for exactly one cycle per field updated: one for the seconds, plus one for each carry taken, up to six cycles when the year changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| reg_addr | input | ADDR_W | Byte address of the register access (index in bits [5:2]) |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | DATA_W | Write data; only bits [3:0] are stored |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |

## Verification
The assertions assume that ticks are far apart compared with an update, which takes at most six cycles. They also assume that software does not write a time digit while an update is running, and that every written digit is a valid BCD value. The field-wrap properties therefore exclude cycles with a write. The bench follows the same rules. It loads every time with stop set and writes only legal digits. After each tick it polls busy through the control register until busy falls, and it sends the next tick only after that.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

    localparam int NIB_W    = 4;
    localparam int IDX_W    = 4;
    localparam int BANK_W   = 2;
    localparam int NUM_DIG  = 15;
    localparam int STRIDE_LSB = 2;

    localparam int SEC_U = 0;
    localparam int SEC_T = 1;
    localparam int MIN_U = 2;
    localparam int MIN_T = 3;
    localparam int HR_U  = 4;
    localparam int HR_T  = 5;
    localparam int DOW   = 6;
    localparam int DAY_U = 7;
    localparam int DAY_T = 8;
    localparam int MON_U = 9;
    localparam int MON_T = 10;
    localparam int YR_U  = 11;
    localparam int YR_T  = 12;
    localparam int YR_H  = 13;
    localparam int YR_K  = 14;

    localparam logic [IDX_W-1:0] IDX_CTRL = 4'd15;

    typedef enum logic [2:0] {
        STG_IDLE,
        STG_SEC,
        STG_MIN,
        STG_HOUR,
        STG_DAY,
        STG_MON,
        STG_YEAR
    } stage_t;

    typedef struct packed {
        logic             carry;
        logic [NIB_W-1:0] tens;
        logic [NIB_W-1:0] units;
    } pair_step_t;

    // Reset value of each digit: 2000-01-01 00:00:00, weekday 0
    function automatic logic [NIB_W-1:0] rst_digit(input int idx);
        case (idx)
            DAY_U, MON_U: return 4'd1;
            YR_K:         return 4'd2;
            default:      return 4'd0;
        endcase
    endfunction

    // Advance a two-digit BCD field; wraps from last to (0, first_u)
    function automatic pair_step_t bcd_pair_step(
        input logic [NIB_W-1:0] t,
        input logic [NIB_W-1:0] u,
        input logic [NIB_W-1:0] last_t,
        input logic [NIB_W-1:0] last_u,
        input logic [NIB_W-1:0] first_u
    );
        pair_step_t r;
        r.carry = 1'b0;
        r.tens  = t;
        r.units = u;
        if (t == last_t && u == last_u) begin
            r.carry = 1'b1;
            r.tens  = 4'd0;
            r.units = first_u;
        end else if (u == 4'd9) begin
            r.tens  = t + 4'd1;
            r.units = 4'd0;
        end else begin
            r.units = u + 4'd1;
        end
        return r;
    endfunction

    // Four-digit BCD year increment, 9999 wraps to 0000
    function automatic logic [4*NIB_W-1:0] bcd_year_step(input logic [4*NIB_W-1:0] y);
        logic [4*NIB_W-1:0] r;
        logic               c;
        c = 1'b1;
        r = y;
        for (int i = 0; i < 4; i++) begin
            if (c) begin
                if (y[i*NIB_W +: NIB_W] == 4'd9) begin
                    r[i*NIB_W +: NIB_W] = 4'd0;
                end else begin
                    r[i*NIB_W +: NIB_W] = y[i*NIB_W +: NIB_W] + 4'd1;
                    c = 1'b0;
                end
            end
        end
        return r;
    endfunction

    // Gregorian leap rule on BCD digits {thousands, hundreds, tens, units}
    function automatic logic is_leap(input logic [4*NIB_W-1:0] y);
        logic [6:0] yy;
        logic [6:0] cc;
        yy = 7'(y[7:4]) * 7'd10 + 7'(y[3:0]);
        cc = 7'(y[15:12]) * 7'd10 + 7'(y[11:8]);
        if (yy != 7'd0) return (yy[1:0] == 2'b00);
        return (cc[1:0] == 2'b00);
    endfunction

    // Last day of a month as a BCD pair {tens, units}
    function automatic logic [2*NIB_W-1:0] month_last_day(
        input logic [NIB_W-1:0] mt,
        input logic [NIB_W-1:0] mu,
        input logic             leap
    );
        logic [7:0] m;
        m = 8'(mt) * 8'd10 + 8'(mu);
        case (m)
            8'd2:                      return leap ? 8'h29 : 8'h28;
            8'd4, 8'd6, 8'd9, 8'd11:   return 8'h30;
            default:                   return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/bcd_cal_seq.sv
module bcd_cal_seq
    import bcd_cal_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick_i,
    input  logic   stop_i,
    input  logic   carry_i,
    output stage_t stage_o,
    output logic   busy_o
);

    stage_t stage_q;
    stage_t stage_d;

    always_comb begin
        stage_d = STG_IDLE;
        case (stage_q)
            STG_IDLE: stage_d = (tick_i && !stop_i) ? STG_SEC : STG_IDLE;
            STG_SEC:  stage_d = carry_i ? STG_MIN  : STG_IDLE;
            STG_MIN:  stage_d = carry_i ? STG_HOUR : STG_IDLE;
            STG_HOUR: stage_d = carry_i ? STG_DAY  : STG_IDLE;
            STG_DAY:  stage_d = carry_i ? STG_MON  : STG_IDLE;
            STG_MON:  stage_d = carry_i ? STG_YEAR : STG_IDLE;
            STG_YEAR: stage_d = STG_IDLE;
            default:  stage_d = STG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) stage_q <= STG_IDLE;
        else     stage_q <= stage_d;
    end

    assign stage_o = stage_q;
    assign busy_o  = (stage_q != STG_IDLE);

    // R12
    year_is_last_chk: assert property (@(posedge clk) disable iff (rst)
        (stage_q == STG_YEAR) |=> (stage_q == STG_IDLE));

    // R12
    no_carry_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !carry_i) |=> !busy_o);

endmodule

// File: rtl/bcd_cal_counter.sv
module bcd_cal_counter
    import bcd_cal_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  stage_t                          stage_i,
    input  logic                            we_i,
    input  logic [IDX_W-1:0]                widx_i,
    input  logic [NIB_W-1:0]                wdata_i,
    output logic [NUM_DIG-1:0][NIB_W-1:0]   digits_o,
    output logic                            carry_o
);

    logic [NUM_DIG-1:0][NIB_W-1:0] d;
    logic [NUM_DIG-1:0]            upd_en;
    logic [NUM_DIG-1:0][NIB_W-1:0] upd_val;

    pair_step_t         sec_p, min_p, hr_p, day_p, mon_p;
    logic [2*NIB_W-1:0] last_day;
    logic [4*NIB_W-1:0] year_now, year_nx;
    logic [NIB_W-1:0]   dow_nx;

    assign year_now = {d[YR_K], d[YR_H], d[YR_T], d[YR_U]};
    assign year_nx  = bcd_year_step(year_now);
    assign last_day = month_last_day(d[MON_T], d[MON_U], is_leap(year_now));
    assign sec_p    = bcd_pair_step(d[SEC_T], d[SEC_U], 4'd5, 4'd9, 4'd0);
    assign min_p    = bcd_pair_step(d[MIN_T], d[MIN_U], 4'd5, 4'd9, 4'd0);
    assign hr_p     = bcd_pair_step(d[HR_T],  d[HR_U],  4'd2, 4'd3, 4'd0);
    assign day_p    = bcd_pair_step(d[DAY_T], d[DAY_U], last_day[7:4], last_day[3:0], 4'd1);
    assign mon_p    = bcd_pair_step(d[MON_T], d[MON_U], 4'd1, 4'd2, 4'd1);
    assign dow_nx   = (d[DOW] >= 4'd6) ? 4'd0 : d[DOW] + 4'd1;

    always_comb begin
        upd_en  = '0;
        upd_val = '0;
        carry_o = 1'b0;
        case (stage_i)
            STG_SEC: begin
                upd_en[SEC_U]  = 1'b1;  upd_val[SEC_U] = sec_p.units;
                upd_en[SEC_T]  = 1'b1;  upd_val[SEC_T] = sec_p.tens;
                carry_o        = sec_p.carry;
            end
            STG_MIN: begin
                upd_en[MIN_U]  = 1'b1;  upd_val[MIN_U] = min_p.units;
                upd_en[MIN_T]  = 1'b1;  upd_val[MIN_T] = min_p.tens;
                carry_o        = min_p.carry;
            end
            STG_HOUR: begin
                upd_en[HR_U]   = 1'b1;  upd_val[HR_U]  = hr_p.units;
                upd_en[HR_T]   = 1'b1;  upd_val[HR_T]  = hr_p.tens;
                carry_o        = hr_p.carry;
            end
            STG_DAY: begin
                upd_en[DAY_U]  = 1'b1;  upd_val[DAY_U] = day_p.units;
                upd_en[DAY_T]  = 1'b1;  upd_val[DAY_T] = day_p.tens;
                upd_en[DOW]    = 1'b1;  upd_val[DOW]   = dow_nx;
                carry_o        = day_p.carry;
            end
            STG_MON: begin
                upd_en[MON_U]  = 1'b1;  upd_val[MON_U] = mon_p.units;
                upd_en[MON_T]  = 1'b1;  upd_val[MON_T] = mon_p.tens;
                carry_o        = mon_p.carry;
            end
            STG_YEAR: begin
                upd_en[YR_U]   = 1'b1;  upd_val[YR_U]  = year_nx[3:0];
                upd_en[YR_T]   = 1'b1;  upd_val[YR_T]  = year_nx[7:4];
                upd_en[YR_H]   = 1'b1;  upd_val[YR_H]  = year_nx[11:8];
                upd_en[YR_K]   = 1'b1;  upd_val[YR_K]  = year_nx[15:12];
            end
            default: ;
        endcase
    end

    // One register per digit; a bus write takes priority over an update
    for (genvar g = 0; g < NUM_DIG; g++) begin : g_digit
        logic [NIB_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)                                q <= rst_digit(g);
            else if (we_i && widx_i == IDX_W'(g))   q <= wdata_i;
            else if (upd_en[g])                     q <= upd_val[g];
        end
        assign d[g] = q;
    end

    assign digits_o = d;

    // R6
    sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (stage_i == STG_SEC && d[SEC_T] == 4'd5 && d[SEC_U] == 4'd9 && !we_i)
        |=> (d[SEC_T] == 4'd0 && d[SEC_U] == 4'd0));

    // R6
    hour_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (stage_i == STG_HOUR && d[HR_T] == 4'd2 && d[HR_U] == 4'd3 && !we_i)
        |=> (d[HR_T] == 4'd0 && d[HR_U] == 4'd0));

    // R7
    day_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (stage_i == STG_DAY && {d[DAY_T], d[DAY_U]} == last_day && !we_i)
        |=> (d[DAY_T] == 4'd0 && d[DAY_U] == 4'd1));

    // R8
    month_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (stage_i == STG_MON && d[MON_T] == 4'd1 && d[MON_U] == 4'd2 && !we_i)
        |=> (d[MON_T] == 4'd0 && d[MON_U] == 4'd1));

    // R9
    dow_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (stage_i == STG_DAY && d[DOW] == 4'd6 && !we_i) |=> (d[DOW] == 4'd0));

endmodule

// File: rtl/bcd_cal_clock.sv
module bcd_cal_clock
    import bcd_cal_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_tick,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);

    localparam int PAD_W = DATA_W - NIB_W;

    logic [IDX_W-1:0]              idx;
    logic [NIB_W-1:0]              wnib;
    logic [NIB_W-1:0]              rnib;
    logic                          stop_q;
    logic [BANK_W-1:0]             bank_q;
    logic                          busy;
    logic                          carry;
    logic                          dig_we;
    stage_t                        stage;
    logic [NUM_DIG-1:0][NIB_W-1:0] digits;
    logic                          unused_bits;

    assign idx         = reg_addr[STRIDE_LSB +: IDX_W];
    assign wnib        = reg_wdata[NIB_W-1:0];
    assign unused_bits = ^{reg_addr, reg_wdata};
    assign dig_we      = reg_wr && (idx != IDX_CTRL) && (bank_q == '0);

    // Control register: stop and bank select are writable, busy is not
    always_ff @(posedge clk) begin
        if (rst) begin
            stop_q <= 1'b0;
            bank_q <= '0;
        end else if (reg_wr && idx == IDX_CTRL) begin
            stop_q <= wnib[1];
            bank_q <= wnib[3:2];
        end
    end

    bcd_cal_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (sec_tick),
        .stop_i  (stop_q),
        .carry_i (carry),
        .stage_o (stage),
        .busy_o  (busy)
    );

    bcd_cal_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .stage_i  (stage),
        .we_i     (dig_we),
        .widx_i   (idx),
        .wdata_i  (wnib),
        .digits_o (digits),
        .carry_o  (carry)
    );

    always_comb begin
        rnib = '0;
        if (idx == IDX_CTRL)    rnib = {bank_q, stop_q, busy};
        else if (bank_q == '0)  rnib = digits[idx];
    end

    assign reg_rdata = {{PAD_W{1'b0}}, rnib};

    // R5
    tick_starts_chk: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && !stop_q && !busy) |=> busy);

    // R10
    stopped_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && stop_q && !busy) |=> !busy);

    // R10
    stopped_secs_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_q && !busy && !reg_wr) |=> $stable(digits[SEC_U]));

endmodule

// File: tb/bcd_cal_clock_tb.sv
`timescale 1ns/1ps
module bcd_cal_clock_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       sec_tick;
    logic [5:0] reg_addr;
    logic       reg_wr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;

    always #2 clk = ~clk;

    bcd_cal_clock #(.ADDR_W(6), .DATA_W(8)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .sec_tick  (sec_tick),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    typedef struct {
        logic [59:0] digs;
        int          stages;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   mon_go = 0;
    int   mon_done = 0;

    int m_sec, m_min, m_hr, m_day, m_mon, m_yr, m_dow;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input int idx, input logic [7:0] v);
        @(negedge clk);
        reg_addr  = 6'(idx * 4);
        reg_wdata = v;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic bus_read(input int idx, input int off, output logic [7:0] v);
        @(negedge clk);
        reg_addr = 6'(idx * 4 + off);
        #1 v = reg_rdata;
    endtask

    function automatic int mdays(input int mon, input int yr);
        bit leap;
        leap = ((yr % 4 == 0) && (yr % 100 != 0)) || (yr % 400 == 0);
        case (mon)
            2:           return leap ? 29 : 28;
            4, 6, 9, 11: return 30;
            default:     return 31;
        endcase
    endfunction

    function automatic logic [59:0] model_digits();
        int v[15];
        logic [59:0] r;
        v = '{m_sec % 10, m_sec / 10, m_min % 10, m_min / 10, m_hr % 10, m_hr / 10,
              m_dow, m_day % 10, m_day / 10, m_mon % 10, m_mon / 10,
              m_yr % 10, (m_yr / 10) % 10, (m_yr / 100) % 10, m_yr / 1000};
        for (int i = 0; i < 15; i++) r[i*4 +: 4] = 4'(v[i]);
        return r;
    endfunction

    // Bench model of one second; returns number of fields touched
    function automatic int model_tick();
        int st;
        st = 1;
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; m_min++; st = 2;
            if (m_min == 60) begin
                m_min = 0; m_hr++; st = 3;
                if (m_hr == 24) begin
                    m_hr = 0; st = 4;
                    m_dow = (m_dow + 1) % 7;
                    m_day++;
                    if (m_day > mdays(m_mon, m_yr)) begin
                        m_day = 1; m_mon++; st = 5;
                        if (m_mon == 13) begin
                            m_mon = 1; st = 6;
                            m_yr = (m_yr + 1) % 10000;
                        end
                    end
                end
            end
        end
        return st;
    endfunction

    task automatic set_time(input int yr, input int mon, input int day, input int dow,
                            input int hr, input int mn, input int sc);
        logic [59:0] dg;
        m_yr = yr; m_mon = mon; m_day = day; m_dow = dow;
        m_hr = hr; m_min = mn; m_sec = sc;
        dg = model_digits();
        bus_write(15, 8'h02);
        for (int i = 0; i < 15; i++) bus_write(i, {4'h0, dg[i*4 +: 4]});
        bus_write(15, 8'h00);
    endtask

    // Driver: push the expected result, pulse the tick, hand off to the monitor
    task automatic do_tick(input string tag);
        exp_t e;
        int   target;
        e.stages = model_tick();
        e.digs   = model_digits();
        e.tag    = tag;
        exp_q.push_back(e);
        @(negedge clk);
        reg_addr = 6'(15 * 4);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        target = mon_done + 1;
        mon_go++;
        wait (mon_done == target);
    endtask

    // Monitor: count busy cycles on the control register, then read back the time
    initial begin : monitor
        int          seen;
        seen = 0;
        forever begin
            int          n;
            logic [7:0]  v;
            logic [59:0] act;
            exp_t        e;
            wait (mon_go != seen);
            seen = mon_go;
            n = 0;
            #1;
            while (reg_rdata[0]) begin
                n++;
                @(negedge clk);
                #1;
            end
            act = '0;
            for (int i = 0; i < 15; i++) begin
                bus_read(i, 0, v);
                act[i*4 +: 4] = v[3:0];
            end
            if (exp_q.size() == 0) begin
                check(1'b0, "R5", "unexpected update", 64'(n), 64'd0);
            end else begin
                e = exp_q.pop_front();
                check(n == e.stages, "R5 R12", "busy cycles", 64'(n), 64'(e.stages));
                check(act == e.digs, e.tag, "time digits", 64'(act), 64'(e.digs));
            end
            mon_done++;
        end
    end

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : driver
        logic [7:0]  v;
        logic [59:0] act;
        rst = 1'b1; sec_tick = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R4 R3: reset state of the control register and the time
        bus_read(15, 0, v);
        check(v == 8'h00, "R4 R3", "control after reset", 64'(v), 64'h0);
        m_yr = 2000; m_mon = 1; m_day = 1; m_dow = 0; m_hr = 0; m_min = 0; m_sec = 0;
        act = '0;
        for (int i = 0; i < 15; i++) begin
            bus_read(i, 0, v);
            act[i*4 +: 4] = v[3:0];
        end
        check(act == model_digits(), "R4 R2", "reset time", 64'(act), 64'(model_digits()));

        do_tick("R5");
        set_time(2000, 1, 31, 3, 0, 0, 59);  do_tick("R6");
        set_time(2000, 1, 31, 3, 10, 59, 59); do_tick("R6");
        set_time(2000, 1, 31, 3, 23, 59, 59); do_tick("R6 R7");
        set_time(2000, 2, 28, 1, 23, 59, 59); do_tick("R7");
        do_tick("R5");
        set_time(2000, 2, 29, 2, 23, 59, 59); do_tick("R7");
        set_time(1900, 2, 28, 3, 23, 59, 59); do_tick("R7");
        set_time(2023, 2, 28, 2, 23, 59, 59); do_tick("R7");
        set_time(2024, 2, 28, 3, 23, 59, 59); do_tick("R7");
        set_time(2001, 4, 30, 1, 23, 59, 59); do_tick("R7");
        set_time(2001, 7, 30, 1, 23, 59, 59); do_tick("R7");
        set_time(2099, 12, 31, 6, 23, 59, 59); do_tick("R8 R9");
        set_time(9999, 12, 31, 5, 23, 59, 59); do_tick("R8");
        set_time(2010, 5, 9, 6, 23, 59, 59); do_tick("R9");

        // R10: ticks under stop are dropped and not replayed
        set_time(2012, 3, 4, 0, 8, 30, 15);
        bus_write(15, 8'h02);
        bus_read(15, 0, v);
        check(v == 8'h02, "R3", "stop bit readback", 64'(v), 64'h02);
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        for (int k = 0; k < 4; k++) begin
            bus_read(15, 0, v);
            check(v[0] == 1'b0, "R10", "busy under stop", 64'(v), 64'h02);
        end
        bus_write(15, 8'h00);
        repeat (6) @(negedge clk);
        act = '0;
        for (int i = 0; i < 15; i++) begin
            bus_read(i, 0, v);
            act[i*4 +: 4] = v[3:0];
        end
        check(act == model_digits(), "R10", "time after stopped tick", 64'(act), 64'(model_digits()));
        do_tick("R10");

        // R1: upper write bits dropped, upper read bits zero, byte offset ignored
        bus_write(15, 8'h02);
        bus_write(2, 8'hA3);
        m_min = 33;
        bus_read(2, 0, v);
        check(v == 8'h03, "R1", "nibble write", 64'(v), 64'h03);
        bus_read(2, 3, v);
        check(v == 8'h03, "R1", "unaligned offset", 64'(v), 64'h03);
        bus_write(15, 8'h00);

        // R11 R3: other banks
        bus_write(15, 8'h04);
        bus_read(15, 0, v);
        check(v == 8'h04, "R3", "bank select readback", 64'(v), 64'h04);
        bus_read(0, 0, v);
        check(v == 8'h00, "R11", "bank 1 digit slot", 64'(v), 64'h00);
        bus_write(0, 8'h09);
        bus_write(4, 8'h07);
        bus_write(15, 8'h0D);
        bus_read(15, 1, v);
        check(v == 8'h0C, "R3", "busy bit not writable, bank 3", 64'(v), 64'h0C);
        bus_write(15, 8'h00);
        act = '0;
        for (int i = 0; i < 15; i++) begin
            bus_read(i, 0, v);
            act[i*4 +: 4] = v[3:0];
        end
        check(act == model_digits(), "R11", "time after bank writes", 64'(act), 64'(model_digits()));
        do_tick("R5");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule